// File: doc/BRIEF.md
# Cascadable Bidirectional Display Line Loader

This block is the digital front end of a flat-panel column driver. It takes six 8-bit subpixel lanes on every rising clock edge and writes them into a 384-channel sampling line. A start pulse arrives on one of two cascade pins and enters a 64-stage one-hot position chain. On each of the next 64 clocks the chain picks which six-channel group receives the lanes. The direction input decides which cascade pin accepts the start pulse, which pin returns the carry pulse, and whether the line fills upward from channel 1 or downward from channel 384.

Each lane group can be complemented before capture, three lanes per control, so the upstream bus can send whichever form toggles fewer wires. A rising edge on the load strobe copies the sampling line into a hold line that drives the per-channel codes. The copy happens whether or not the line is complete. The same edge latches a polarity bit, which sets one polarity for all even channels and the opposite polarity for all odd channels. When several devices are chained, each device's carry pin feeds the start pin of the next.

Top module: `panel_line_loader`

## Requirements
- R1: A synchronous active-high reset clears the position chain and the latched polarity. In the cycle after reset is released both cascade outputs are 0 and `pos_flag` shows polarity 0.
- R2: With `dir_right`=1 the start pulse is taken from `cas_l_in`. At capture step s (0..63), lane i (bits 8i+7:8i of `lanes`) is written to channel 6s+i+1. Channel n (1-based) appears on `code_out` bits 8(n-1)+7:8(n-1).
- R3: With `dir_right`=0 the start pulse is taken from `cas_r_in`. At capture step s, lane i is written to channel 6(63-s)+i+1, so the first step fills channels 379..384 and the last step fills channels 1..6.
- R4: The rising edge that first samples the start pin high arms the chain. The 64 following rising edges capture steps 0..63. After that, lane data has no effect until a new start pulse arrives.
- R5: A start pulse held high for several clocks counts as one start event, and capture begins on the edge after the first high sample.
- R6: After the 64th capture edge the carry pin on the far side is high for exactly one clock: `cas_r_out` when `dir_right`=1, `cas_l_out` when `dir_right`=0. The other carry pin stays 0 throughout.
- R7: While `inv_lo`=1, lanes 0..2 are stored bitwise complemented. While `inv_hi`=1, lanes 3..5 are stored complemented. The controls are applied at the capture edge, for example 0x07 is stored as 0xF8.
- R8: `code_out` changes only on a clock edge where `load` is sampled 1 after having been 0. Holding `load` high does not copy again.
- R9: A load edge that arrives while a line is still being filled copies the sampling line as it stood before that edge. Channels not yet written keep their earlier contents.
- R10: The load edge latches `pol`. With `pol`=1 the even channels (1-based) are flagged positive (`pos_flag` bit n-1 = 1) and the odd channels negative. With `pol`=0 the assignment is reversed. Changing `pol` without a load edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_right | input | 1 | 1: start on left pin, fill upward; 0: start on right pin, fill downward; held steady during a line |
| cas_l_in | input | 1 | Left cascade start input (used when `dir_right`=1) |
| cas_r_in | input | 1 | Right cascade start input (used when `dir_right`=0) |
| cas_l_out | output | 1 | Left cascade carry output (active when `dir_right`=0) |
| cas_r_out | output | 1 | Right cascade carry output (active when `dir_right`=1) |
| lanes | input | 48 | Six 8-bit subpixel lanes, lane i at bits 8i+7:8i |
| inv_lo | input | 1 | Complement lanes 0..2 at capture |
| inv_hi | input | 1 | Complement lanes 3..5 at capture |
| load | input | 1 | Load strobe; rising edge copies the line and latches polarity |
| pol | input | 1 | Dot-inversion polarity, latched on the load edge |
| code_out | output | 3072 | Held 8-bit code per channel, channel n at bits 8(n-1)+7:8(n-1) |
| pos_flag | output | 384 | Per-channel polarity flag, 1 = positive, bit n-1 for channel n |

## Verification
Lanes presented before a capture edge reach the sampling line at that edge. They become visible on `code_out` only in the cycle after the edge that samples a rising `load`, and `pos_flag` follows on that same cycle. The carry pulse can be seen in the one cycle after the 64th capture edge, and it must be low again one cycle later. For every stimulus, the driver pushes the expected result into the scoreboard tagged with the count of the next rising edge. The monitor compares only at the falling edge that follows that count, so each value is checked exactly one register stage after its cause and never while inputs are changing.

// File: rtl/panel_line_loader.sv
module panel_line_loader #(
  parameter int W      = 8,
  parameter int LANES  = 6,
  parameter int STEPS  = 64,
  parameter int LO_CNT = 3
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         dir_right,
  input  logic                         cas_l_in,
  input  logic                         cas_r_in,
  output logic                         cas_l_out,
  output logic                         cas_r_out,
  input  logic [LANES*W-1:0]           lanes,
  input  logic                         inv_lo,
  input  logic                         inv_hi,
  input  logic                         load,
  input  logic                         pol,
  output logic [LANES*STEPS*W-1:0]     code_out,
  output logic [LANES*STEPS-1:0]       pos_flag
);
  localparam int CH = LANES * STEPS;
  localparam int LW = LANES * W;

  logic             start_q, load_q, pol_q, carry_q;
  logic [STEPS-1:0] tok, grp_we;
  logic [CH*W-1:0]  samp, hold;
  logic [LW-1:0]    lanes_x;

  wire start_in   = dir_right ? cas_l_in : cas_r_in;
  wire start_rise = start_in & ~start_q;
  wire load_rise  = load & ~load_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < LO_CNT) begin : g_lo
      assign lanes_x[i*W +: W] = lanes[i*W +: W] ^ {W{inv_lo}};
    end else begin : g_hi
      assign lanes_x[i*W +: W] = lanes[i*W +: W] ^ {W{inv_hi}};
    end
  end

  for (genvar g = 0; g < STEPS; g++) begin : g_grp
    assign grp_we[g] = dir_right ? tok[g] : tok[STEPS-1-g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      load_q  <= 1'b0;
      pol_q   <= 1'b0;
      carry_q <= 1'b0;
      tok     <= '0;
    end else begin
      start_q <= start_in;
      load_q  <= load;
      carry_q <= tok[STEPS-1];
      if (start_rise) tok <= {{(STEPS-1){1'b0}}, 1'b1};
      else            tok <= tok << 1;
      if (load_rise)  pol_q <= pol;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int g = 0; g < STEPS; g++)
        if (grp_we[g]) samp[g*LW +: LW] <= lanes_x;
      if (load_rise) hold <= samp;
    end
  end

  assign cas_r_out = dir_right & carry_q;
  assign cas_l_out = ~dir_right & carry_q;
  assign code_out  = hold;

  for (genvar c = 0; c < CH; c++) begin : g_pol
    if (c % 2 == 1) begin : g_even_ch
      assign pos_flag[c] = pol_q;
    end else begin : g_odd_ch
      assign pos_flag[c] = ~pol_q;
    end
  end
endmodule

// File: rtl/panel_line_loader_chk.sv
module panel_line_loader_chk #(
  parameter int W  = 8,
  parameter int CH = 384
) (
  input logic            clk,
  input logic            rst,
  input logic            load,
  input logic            pol,
  input logic            cas_l_out,
  input logic            cas_r_out,
  input logic [CH*W-1:0] code_out,
  input logic [CH-1:0]   pos_flag
);
  AST_RESET_QUIET: assert property (@(posedge clk) ($past(rst) && !rst) |-> (!cas_l_out && !cas_r_out)); // R1
  AST_CARRY_R_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) cas_r_out |=> !cas_r_out); // R6
  AST_CARRY_L_ONE_WIDE: assert property (@(posedge clk) disable iff (rst) cas_l_out |=> !cas_l_out); // R6
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(code_out)); // R8
  AST_POL_NO_STROBE: assert property (@(posedge clk) disable iff (rst) !load |=> $stable(pos_flag)); // R10
  AST_POL_CAPTURE: assert property (@(posedge clk) disable iff (rst) (load && !$past(load)) |=> (pos_flag[1] == $past(pol))); // R10
endmodule

bind panel_line_loader panel_line_loader_chk #(.W(W), .CH(CH)) chk_i (
  .clk(clk), .rst(rst), .load(load), .pol(pol),
  .cas_l_out(cas_l_out), .cas_r_out(cas_r_out),
  .code_out(code_out), .pos_flag(pos_flag)
);

// File: tb/panel_line_loader_tb_top.sv
`timescale 1ns/1ps
module panel_line_loader_tb_top;
  localparam int W = 8, LANES = 6, STEPS = 64, CH = LANES * STEPS;

  logic clk = 0, rst = 1, dir_right = 1, cas_l_in = 0, cas_r_in = 0;
  logic inv_lo = 0, inv_hi = 0, load = 0, pol = 0;
  logic [LANES*W-1:0] lanes = '0;
  wire cas_l_out, cas_r_out;
  wire [CH*W-1:0] code_out;
  wire [CH-1:0] pos_flag;

  always #4 clk = ~clk;

  panel_line_loader dut_i (
    .clk(clk), .rst(rst), .dir_right(dir_right),
    .cas_l_in(cas_l_in), .cas_r_in(cas_r_in),
    .cas_l_out(cas_l_out), .cas_r_out(cas_r_out),
    .lanes(lanes), .inv_lo(inv_lo), .inv_hi(inv_hi),
    .load(load), .pol(pol), .code_out(code_out), .pos_flag(pos_flag)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int due; int kind; int idx; int exp; string req; } item_t;
  item_t sb[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] exp_samp [CH];
  logic [7:0] exp_hold [CH];

  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      case (it.kind)
        0:       act = code_out[it.idx*W +: W];
        1:       act = {7'b0, pos_flag[it.idx]};
        2:       act = {7'b0, cas_l_out};
        default: act = {7'b0, cas_r_out};
      endcase
      n_run++;
      if (act !== 8'(it.exp)) begin
        n_fail++;
        $display("FAIL %s kind=%0d idx=%0d actual=%h expected=%h", it.req, it.kind, it.idx, act, 8'(it.exp));
      end
    end
  end

  task automatic expect_it(int kind, int idx, int v, string req);
    item_t it;
    it.due = cyc + 1; it.kind = kind; it.idx = idx; it.exp = v; it.req = req;
    sb.push_back(it);
  endtask

  task automatic expect_hold(string req);
    for (int c = 0; c < CH; c++) expect_it(0, c, int'(exp_hold[c]), req);
  endtask

  task automatic expect_pol(bit p, string req);
    for (int c = 0; c < CH; c++)
      if (c < 4 || c >= CH - 2) expect_it(1, c, p ? (c % 2) : 1 - (c % 2), req);
  endtask

  function automatic logic [7:0] pat(int seed, int s, int i);
    return 8'(seed * 37 + s * 11 + i * 53 + s * i);
  endfunction

  task automatic run_line(bit d, int width, int seed, bit il, bit ih, int load_at);
    dir_right = d;
    if (d) cas_l_in = 1; else cas_r_in = 1;
    @(negedge clk);
    for (int s = 0; s < STEPS; s++) begin
      if (d) cas_l_in = (s + 1 < width); else cas_r_in = (s + 1 < width);
      if (s == load_at) begin
        load = 1;
        exp_hold = exp_samp;
        expect_hold("R9");
      end else if (load_at >= 0 && s == load_at + 1) load = 0;
      inv_lo = il; inv_hi = ih;
      for (int i = 0; i < LANES; i++) begin
        logic [7:0] v;
        int idx;
        v = pat(seed, s, i);
        lanes[i*W +: W] = v;
        if ((i < 3) ? il : ih) v = ~v;
        idx = d ? s * LANES + i : (STEPS - 1 - s) * LANES + i;
        exp_samp[idx] = v;
      end
      expect_it(d ? 3 : 2, 0, (s == STEPS - 1) ? 1 : 0, "R6");
      expect_it(d ? 2 : 3, 0, 0, "R6");
      @(negedge clk);
    end
    expect_it(d ? 3 : 2, 0, 0, "R6");
    expect_it(d ? 2 : 3, 0, 0, "R6");
    if (load_at >= 0) load = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n, int seed);
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < LANES; i++) lanes[i*W +: W] = pat(seed, k, i);
      inv_lo = k[0];
      @(negedge clk);
    end
  endtask

  task automatic do_load(bit p, bit keep, string req);
    load = 1; pol = p;
    exp_hold = exp_samp;
    expect_hold(req);
    expect_pol(p, "R10");
    @(negedge clk);
    if (!keep) load = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    expect_it(2, 0, 0, "R1");
    expect_it(3, 0, 0, "R1");
    expect_pol(0, "R1");
    @(negedge clk);

    // R2 upward fill, R4 data after 64 captures ignored
    run_line(1, 1, 5, 0, 0, -1);
    idle(5, 9);
    do_load(1, 0, "R2/R4");

    // R10 polarity change without a load edge
    pol = 0;
    idle(3, 4);
    expect_pol(1, "R10");
    @(negedge clk);

    // R8 load held high during a new line, R3 downward, R5 wide start, R7 low group
    do_load(1, 1, "R8");
    run_line(0, 3, 7, 1, 0, -1);
    expect_hold("R8");
    @(negedge clk);
    load = 0;
    @(negedge clk);
    do_load(0, 0, "R3/R5/R7");

    // R9 partial line load, R7 high group inverted
    run_line(1, 1, 11, 0, 1, 10);
    do_load(1, 0, "R2/R7");

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule